// File: doc/BRIEF.md
# Nibble Accumulator Processor Core

This block is a minimal processor with separate program and data storage. It fetches one 8-bit instruction per clock from an external program memory through a 12-bit address. It keeps a single 4-bit accumulator, a 256-word by 4-bit data RAM, a 4-bit page register and a 4-bit output register, and it reads a 4-bit input port. The upper nibble of each instruction word drives the datapath selects directly, with no decode table. The lower nibble is either an immediate value or the low half of a RAM address. The page register supplies the high half of that address.

The arithmetic unit can load, add and NAND. It keeps no carry or status flag, and the carry out of the adder is dropped. Programs that need multi-nibble arithmetic build the carry in software from the top bit of a partial sum. The only branch condition is a test that the accumulator is non-zero, formed by ORing its four bits together. Jumps take two instruction words and two cycles. Every other instruction takes one cycle.

Top module: `nib_cpu`

## Requirements
- R1: A synchronous active-high reset clears the program counter, accumulator, page register and output register to zero, so the fetch address and the output port both read 0 after reset.
- R2: Instruction bit 4 selects the operand. A value of 0 takes the instruction's low nibble as the value. A value of 1 reads the RAM word at address {page, low nibble}. Opcodes 0000 and 0001 load that operand into the accumulator.
- R3: Opcodes 0010 and 0011 replace the accumulator with the 4-bit sum of the accumulator and the operand. The carry out is discarded, so 0xD + 0x7 gives 0x4.
- R4: Opcodes 0100 and 0101 replace the accumulator with the bitwise NAND of the accumulator and the operand.
- R5: Opcodes 0110 and 0111 copy the input port into the accumulator, whatever the low nibble holds.
- R6: Any opcode with bit 7 of the instruction set leaves the accumulator unchanged. This includes the unused codes 1011, 1110 and 1111, which do nothing at all.
- R7: Opcode 1000 writes the accumulator into RAM at {page, low nibble}. Opcode 1010 loads the low nibble into the page register, which forms the upper four RAM address bits for every later RAM access.
- R8: Opcode 1001 copies the accumulator to the output register. The output port changes on no other instruction.
- R9: Opcode 1100 is an unconditional jump of two words. The low nibble gives target bits 11:8 and the following program byte gives bits 7:0. The jump takes two cycles.
- R10: Opcode 1101 jumps the same way only when the accumulator is non-zero. When it is not taken, it still uses two cycles and continues at the instruction after its second word.
- R11: Each non-jump instruction takes exactly one cycle, and the fetch address then advances by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| romAddr | output | 12 | Program memory fetch address |
| romData | input | 8 | Instruction byte at romAddr, read combinationally |
| portIn | input | 4 | Input port |
| portOut | output | 4 | Output port register |

## Verification
The main workload is a two-nibble addition of 0xFF and 0x52. The program rebuilds the carry in software from the adder's top bit, using AND and OR made from NAND, and stores the result in RAM words 4 and 5. A wrong sum or a broken branch shows up in the expected 0x51. Further sequences test each operation in turn:
- An input-port read.
- An immediate NAND.
- An add that overflows, which separates a dropped carry from a kept one.
- The same RAM offset under two page values, which separates paging from plain 4-bit addressing.
- The write-disabled no-op codes.
- A non-taken conditional jump over a zero target.
- A jump to a target above 0xFF, which checks that the high nibble is carried into the address.

A behavioural model in the bench runs alongside the design and is compared on fetch address and output every cycle.

// File: rtl/nib_pkg.sv
package nib_pkg;
  localparam int NIB_W = 4;
  localparam int INS_W = 2 * NIB_W;

  typedef enum logic [1:0] {
    SRC_LOAD = 2'b00,
    SRC_ADD  = 2'b01,
    SRC_NAND = 2'b10,
    SRC_PORT = 2'b11
  } accSrc_e;

  typedef enum logic {
    ST_EXEC = 1'b0,
    ST_TAIL = 1'b1
  } ctrlState_e;

  typedef struct packed {
    logic             accWe;
    accSrc_e          accSel;
    logic             opSel;
    logic             ramWe;
    logic             outWe;
    logic             pageWe;
    logic [NIB_W-1:0] nib;
  } strobe_t;
endpackage

// File: rtl/nib_ctrl.sv
module nib_ctrl
  import nib_pkg::*;
#(
  parameter int PC_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [INS_W-1:0] romData,
  input  logic             accNz,
  output logic [PC_W-1:0]  romAddr,
  output strobe_t          strobe
);
  localparam int HI_W = PC_W - INS_W;

  ctrlState_e      state;
  logic [PC_W-1:0] pc;
  logic [HI_W-1:0] hiReg;
  logic            takeReg;
  logic [NIB_W-1:0] op;
  logic            isJump;
  logic            jumpTaken;

  assign op     = romData[INS_W-1:NIB_W];
  assign isJump = (state == ST_EXEC) && (op[3:1] == 3'b110);
  // Opcode bit 0 clear means unconditional; set means taken only on non-zero.
  assign jumpTaken = !op[0] || accNz;
  assign romAddr = pc;

  always_comb begin
    strobe = '0;
    strobe.nib = romData[NIB_W-1:0];
    if (state == ST_EXEC) begin
      strobe.accWe  = ~op[3];
      strobe.accSel = accSrc_e'(op[2:1]);
      strobe.opSel  = op[0];
      strobe.ramWe  = (op == 4'b1000);
      strobe.outWe  = (op == 4'b1001);
      strobe.pageWe = (op == 4'b1010);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_EXEC;
      pc      <= '0;
      hiReg   <= '0;
      takeReg <= 1'b0;
    end else if (state == ST_EXEC) begin
      pc <= pc + 1'b1;
      if (isJump) begin
        hiReg   <= romData[HI_W-1:0];
        takeReg <= jumpTaken;
        state   <= ST_TAIL;
      end
    end else begin
      state <= ST_EXEC;
      if (takeReg) pc <= {hiReg, romData};
      else         pc <= pc + 1'b1;
    end
  end

  p_step_r11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && op[3:1] != 3'b110) |=> (romAddr == $past(romAddr) + 1'b1));

  p_tail_len_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TAIL) |=> (state == ST_EXEC));

  p_target_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TAIL && takeReg) |=> (romAddr == {$past(hiReg), $past(romData)}));

  p_skip_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TAIL && !takeReg) |=> (romAddr == $past(romAddr) + 1'b1));
endmodule

// File: rtl/nib_dpath.sv
module nib_dpath
  import nib_pkg::*;
#(
  parameter int PAGE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strobe,
  input  logic [NIB_W-1:0] portIn,
  output logic [NIB_W-1:0] portOut,
  output logic             accNz
);
  localparam int RAM_AW    = PAGE_W + NIB_W;
  localparam int RAM_WORDS = 1 << RAM_AW;

  logic [NIB_W-1:0]  acc;
  logic [PAGE_W-1:0] page;
  logic [NIB_W-1:0]  mem [RAM_WORDS];
  logic [RAM_AW-1:0] ramAddr;
  logic [NIB_W-1:0]  operand;
  logic [NIB_W-1:0]  accNext;

  assign ramAddr = {page, strobe.nib};
  assign operand = strobe.opSel ? mem[ramAddr] : strobe.nib;
  assign accNz   = |acc;

  always_comb begin
    unique case (strobe.accSel)
      SRC_LOAD: accNext = operand;
      SRC_ADD:  accNext = acc + operand;   // carry out discarded
      SRC_NAND: accNext = ~(acc & operand);
      SRC_PORT: accNext = portIn;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      page    <= '0;
      portOut <= '0;
    end else begin
      if (strobe.accWe)  acc     <= accNext;
      if (strobe.pageWe) page    <= strobe.nib[PAGE_W-1:0];
      if (strobe.outWe)  portOut <= acc;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.ramWe) mem[ramAddr] <= acc;
  end

  p_one_write_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.accWe, strobe.ramWe, strobe.outWe, strobe.pageWe}));

  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !strobe.outWe |=> $stable(portOut));

  p_out_copy_r8: assert property (@(posedge clk) disable iff (rst)
    strobe.outWe |=> (portOut == $past(acc)));

  p_page_r7: assert property (@(posedge clk) disable iff (rst)
    strobe.pageWe |=> (page == $past(strobe.nib[PAGE_W-1:0])));
endmodule

// File: rtl/nib_cpu.sv
module nib_cpu
  import nib_pkg::*;
#(
  parameter int PC_W   = 12,
  parameter int PAGE_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [PC_W-1:0]      romAddr,
  input  logic [2*NIB_W-1:0]   romData,
  input  logic [NIB_W-1:0]     portIn,
  output logic [NIB_W-1:0]     portOut
);
  strobe_t strobe;
  logic    accNz;

  nib_ctrl #(.PC_W(PC_W)) u_ctrl (
    .clk(clk), .rst(rst), .romData(romData), .accNz(accNz),
    .romAddr(romAddr), .strobe(strobe)
  );

  nib_dpath #(.PAGE_W(PAGE_W)) u_dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .portIn(portIn),
    .portOut(portOut), .accNz(accNz)
  );

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (romAddr == '0 && portOut == '0));
endmodule

// File: tb/nib_cpu_bench.sv
module nib_cpu_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ROM_N = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] romAddr;
  logic [7:0]  romData;
  logic [3:0]  portIn = 4'hA;
  logic [3:0]  portOut;
  logic [7:0]  rom [ROM_N];

  int total = 0, bad = 0;
  bit finished = 0;

  int mPc, mAcc, mPage, mOut, mPhase, mHi, mTake;
  int mRam [256];
  bit lastOut;
  int hist [$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign romData = (romAddr < ROM_N) ? rom[romAddr[8:0]] : 8'h00;

  nib_cpu u_nib_cpu (
    .clk(clk), .rst(rst), .romAddr(romAddr), .romData(romData),
    .portIn(portIn), .portOut(portOut)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelStep();
    int ins, op, v, addr, opnd;
    lastOut = 0;
    if (mPhase == 0) begin
      ins  = (mPc < ROM_N) ? int'(rom[mPc]) : 0;
      op   = ins / 16;
      v    = ins % 16;
      addr = mPage * 16 + v;
      opnd = (op % 2 == 1) ? mRam[addr] : v;
      case (op)
        0, 1:   mAcc = opnd;
        2, 3:   mAcc = (mAcc + opnd) % 16;
        4, 5:   mAcc = 15 - (mAcc & opnd);
        6, 7:   mAcc = int'(portIn);
        8:      mRam[addr] = mAcc;
        9:      begin mOut = mAcc; lastOut = 1; end
        10:     mPage = v;
        12, 13: begin mHi = v; mTake = (op == 12 || mAcc != 0) ? 1 : 0; mPhase = 1; end
        default: ;
      endcase
      mPc = (mPc + 1) % 4096;
    end else begin
      if (mTake != 0) mPc = mHi * 256 + ((mPc < ROM_N) ? int'(rom[mPc]) : 0);
      else            mPc = (mPc + 1) % 4096;
      mPhase = 0;
    end
  endtask

  task automatic put(int a, int b);
    rom[a] = b[7:0];
  endtask

  initial begin
    for (int i = 0; i < ROM_N; i++) rom[i] = 8'h00;
    for (int i = 0; i < 256; i++) mRam[i] = 0;
    // store a=0xFF at $0/$1, b=0x52 at $2/$3
    put(0, 8'h0F); put(1, 8'h80); put(2, 8'h0F); put(3, 8'h81);
    put(4, 8'h05); put(5, 8'h82); put(6, 8'h02); put(7, 8'h83);
    // low nibble sum, software carry
    put(8, 8'h11); put(9, 8'h33); put(10, 8'h85); put(11, 8'h48);
    put(12, 8'h4F); put(13, 8'hD0); put(14, 8'd23);
    put(15, 8'h11); put(16, 8'h4F); put(17, 8'h8F); put(18, 8'h13);
    put(19, 8'h4F); put(20, 8'h5F); put(21, 8'hC0); put(22, 8'd26);
    put(23, 8'h11); put(24, 8'h53); put(25, 8'h4F);
    put(26, 8'h48); put(27, 8'h4F); put(28, 8'hD0); put(29, 8'd32);
    put(30, 8'hC0); put(31, 8'd33);
    put(32, 8'h01); put(33, 8'h30); put(34, 8'h32); put(35, 8'h84);
    // emit results
    put(36, 8'h14); put(37, 8'h90); put(38, 8'h15); put(39, 8'h90);
    // port, nand, overflowing add
    put(40, 8'h60); put(41, 8'h90); put(42, 8'h46); put(43, 8'h90);
    put(44, 8'h27); put(45, 8'h90);
    // paging
    put(46, 8'hA3); put(47, 8'h87); put(48, 8'h09); put(49, 8'hA0);
    put(50, 8'h87); put(51, 8'hA3); put(52, 8'h17); put(53, 8'h90);
    put(54, 8'hA0); put(55, 8'h17); put(56, 8'h90);
    // write-disabled codes
    put(57, 8'hB0); put(58, 8'hE5); put(59, 8'hF7); put(60, 8'h90);
    // jnz on zero, not taken
    put(61, 8'h00); put(62, 8'hD0); put(63, 8'h00);
    put(64, 8'h06); put(65, 8'h90);
    // far jump to 0x123, then spin
    put(66, 8'hC1); put(67, 8'h23);
    put(291, 8'h03); put(292, 8'h90); put(293, 8'hC1); put(294, 8'h25);

    mPc = 0; mAcc = 0; mPage = 0; mOut = 0; mPhase = 0; mHi = 0; mTake = 0;
    lastOut = 0;

    repeat (3) @(negedge clk);
    check("R1 reset fetch address", int'(romAddr), 0);
    check("R1 reset output", int'(portOut), 0);
    rst = 1'b0;

    for (int cyc = 0; cyc < 400; cyc++) begin
      check("R11 fetch address vs model", int'(romAddr), mPc);
      check("R8 output vs model", int'(portOut), mOut);
      if (lastOut) hist.push_back(int'(portOut));
      modelStep();
      @(negedge clk);
    end

    check("R9 output write count", hist.size(), 10);
    if (hist.size() >= 10) begin
      check("R2 R3 sum high nibble", hist[0], 5);
      check("R3 sum low nibble", hist[1], 1);
      check("R5 input port", hist[2], 4'hA);
      check("R4 nand immediate", hist[3], 4'hD);
      check("R3 carry dropped", hist[4], 4);
      check("R7 page 3 read", hist[5], 4);
      check("R7 page 0 read", hist[6], 9);
      check("R6 no-op codes keep acc", hist[7], 9);
      check("R10 not-taken skip", hist[8], 6);
      check("R9 far jump", hist[9], 3);
    end
    check("R9 spin loop", (romAddr == 12'h125 || romAddr == 12'h126) ? 1 : 0, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule